// File: doc/BRIEF.md
# E1 Resynchronization Criteria Monitor

This block sits beside an E1 receive framer. It decides when repeated alignment failures are bad enough to justify a new alignment search. The framer hands it three streams of check results. Each stream is a one-cycle valid strobe together with an error flag:

- frame alignment word checks (FAS);
- CAS multiframe alignment word checks;
- CRC4 codeword checks.

Each alignment level has its own loss rule. FAS and CAS words count as lost after an unbroken run of errored words. CRC4 codewords are judged as a whole block: the block fails when the share of errored codewords in it reaches a threshold.

Each rule that is met sets a sticky event bit in an 8-bit status byte. Software clears an event by writing a 1 to that bit position through a clear-mask strobe. The block also passes the synchronizer's three "search in progress" levels to a status output. These levels are live and are never latched.

Top module: `e1_resync_monitor`

## Requirements
- R1: With `FAS_RUN`=3, `event_status` bit 1 is set on the clock edge that takes the third consecutive errored FAS check (`fas_chk_vld`=1, `fas_chk_err`=1). While the run continues, each further errored FAS check meets the criterion again.
- R2: With `CAS_RUN`=2, `event_status` bit 0 is set on the clock edge that takes the second consecutive errored CAS check. While the run continues, each further errored CAS check meets the criterion again.
- R3: A check with its valid strobe high and its error flag low resets that stream's run of errors to zero. A cycle with the valid strobe low leaves the run unchanged, whatever the error flag holds.
- R4: CRC4 checks are grouped into consecutive blocks of `CRC_BLOCK` valid checks. `event_status` bit 2 is set on the edge that takes the last check of a block, when the block held at least `CRC_LIMIT` errored checks (defaults 1000 and 915).
- R5: At the end of every block, both the codeword count and the error count return to zero. Errors therefore never carry from one block into the next.
- R6: `event_status[7:3]` always reads zero.
- R7: An event bit stays set until a cycle with `clr_wr`=1 and a 1 in the same bit of `clr_mask` clears it. Mask bits that are 0 leave their events unchanged.
- R8: When an event's criterion is met in the same cycle as a clear of that bit, the bit stays set.
- R9: `search_status` follows its inputs in the same cycle with no register: bit 2 = `fas_search`, bit 1 = `cas_search`, bit 0 = `crc_search`.
- R10: A synchronous reset (`rst`=1 at a clock edge) clears all event bits, both error runs and both CRC4 counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fas_chk_vld | input | 1 | FAS word check strobe |
| fas_chk_err | input | 1 | FAS word received in error |
| cas_chk_vld | input | 1 | CAS multiframe alignment word check strobe |
| cas_chk_err | input | 1 | CAS alignment word received in error |
| crc_chk_vld | input | 1 | CRC4 codeword check strobe |
| crc_chk_err | input | 1 | CRC4 codeword received in error |
| fas_search | input | 1 | Synchronizer searching at frame level |
| cas_search | input | 1 | Synchronizer searching for CAS multiframe |
| crc_search | input | 1 | Synchronizer searching for CRC4 multiframe |
| clr_wr | input | 1 | Event clear write strobe |
| clr_mask | input | 3 | Write-1-to-clear mask (bit 0 CAS, bit 1 FAS, bit 2 CRC) |
| event_status | output | 8 | Sticky events: bit 0 CAS, bit 1 FAS, bit 2 CRC, bits 7:3 zero |
| search_status | output | 3 | Live search levels: bit 2 FAS, bit 1 CAS, bit 0 CRC4 |

## Verification
The bench keeps the default run lengths (`FAS_RUN`=3 and `CAS_RUN`=2). It shrinks the CRC4 block to `CRC_BLOCK`=40 with `CRC_LIMIT`=37, which keeps roughly the same error ratio. Each block then takes only a few dozen strobes. Random traffic can therefore cover many block boundaries, with both passing and failing blocks. Directed cases can hit exactly the limit and one below it, and can check that a nearly failing block does not carry into the next one.

// File: rtl/e1rs_pkg.sv
package e1rs_pkg;

    localparam int EVT_CAS_BIT = 0;
    localparam int EVT_FAS_BIT = 1;
    localparam int EVT_CRC_BIT = 2;
    localparam int N_EVT       = 3;
    localparam int STATUS_W    = 8;

    // One strobed check result from the framer
    typedef struct packed {
        logic vld;
        logic err;
    } chk_t;

    // Criterion vector; packed order gives crc at bit 2 and cas at bit 0
    typedef struct packed {
        logic crc;
        logic fas;
        logic cas;
    } crit_t;

    typedef enum logic [1:0] {
        CHK_IDLE = 2'd0,
        CHK_GOOD = 2'd1,
        CHK_BAD  = 2'd2
    } chk_kind_e;

    function automatic chk_kind_e classify(chk_t c);
        if (!c.vld)
            return CHK_IDLE;
        else if (c.err)
            return CHK_BAD;
        else
            return CHK_GOOD;
    endfunction

    function automatic logic [STATUS_W-1:0] pack_status(crit_t c);
        return {{(STATUS_W-N_EVT){1'b0}}, c};
    endfunction

endpackage

// File: rtl/e1rs_run_det.sv
module e1rs_run_det
    import e1rs_pkg::*;
#(
    parameter int RUN = 3
) (
    input  logic clk,
    input  logic rst,
    input  chk_t chk,
    output logic hit
);
    localparam int CW = $clog2(RUN + 1);
    localparam logic [CW-1:0] LIM    = CW'(RUN);
    localparam logic [CW-1:0] LIM_M1 = CW'(RUN - 1);

    logic [CW-1:0] cnt_q, cnt_d;
    chk_kind_e     kind;

    always_comb begin
        kind  = classify(chk);
        hit   = (kind == CHK_BAD) && (cnt_q >= LIM_M1);
        cnt_d = cnt_q;
        case (kind)
            CHK_GOOD: cnt_d = '0;
            CHK_BAD:  cnt_d = (cnt_q == LIM) ? cnt_q : cnt_q + 1'b1;
            default:  cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/e1rs_blk_cnt.sv
module e1rs_blk_cnt
    import e1rs_pkg::*;
#(
    parameter int BLOCK = 1000,
    parameter int LIMIT = 915
) (
    input  logic clk,
    input  logic rst,
    input  chk_t chk,
    output logic hit
);
    localparam int CNT_W = $clog2(BLOCK + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOCK - 1);
    localparam logic [CNT_W:0]   THR  = (CNT_W+1)'(LIMIT);

    logic [CNT_W-1:0] cw_q, err_q;
    logic [CNT_W:0]   err_tot;
    logic             last;

    always_comb begin
        last    = (cw_q == LAST);
        err_tot = {1'b0, err_q} + (CNT_W+1)'(chk.err);
        hit     = chk.vld && last && (err_tot >= THR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cw_q  <= '0;
            err_q <= '0;
        end else if (chk.vld) begin
            if (last) begin
                cw_q  <= '0;
                err_q <= '0;
            end else begin
                cw_q  <= cw_q + 1'b1;
                err_q <= err_tot[CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/e1rs_evt_reg.sv
module e1rs_evt_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] evt_q
);
    for (genvar k = 0; k < N; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                evt_q[k] <= 1'b0;
            else if (set_i[k])
                evt_q[k] <= 1'b1;
            else if (clr_i[k])
                evt_q[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/e1_resync_monitor.sv
module e1_resync_monitor
    import e1rs_pkg::*;
#(
    parameter int FAS_RUN   = 3,
    parameter int CAS_RUN   = 2,
    parameter int CRC_BLOCK = 1000,
    parameter int CRC_LIMIT = 915
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fas_chk_vld,
    input  logic       fas_chk_err,
    input  logic       cas_chk_vld,
    input  logic       cas_chk_err,
    input  logic       crc_chk_vld,
    input  logic       crc_chk_err,
    input  logic       fas_search,
    input  logic       cas_search,
    input  logic       crc_search,
    input  logic       clr_wr,
    input  logic [2:0] clr_mask,
    output logic [7:0] event_status,
    output logic [2:0] search_status
);
    chk_t  fas_c, cas_c, crc_c;
    crit_t hits, evts, clrs;

    assign fas_c = '{vld: fas_chk_vld, err: fas_chk_err};
    assign cas_c = '{vld: cas_chk_vld, err: cas_chk_err};
    assign crc_c = '{vld: crc_chk_vld, err: crc_chk_err};

    e1rs_run_det #(.RUN(FAS_RUN)) u_fas (
        .clk(clk), .rst(rst), .chk(fas_c), .hit(hits.fas)
    );

    e1rs_run_det #(.RUN(CAS_RUN)) u_cas (
        .clk(clk), .rst(rst), .chk(cas_c), .hit(hits.cas)
    );

    e1rs_blk_cnt #(.BLOCK(CRC_BLOCK), .LIMIT(CRC_LIMIT)) u_crc (
        .clk(clk), .rst(rst), .chk(crc_c), .hit(hits.crc)
    );

    assign clrs = clr_wr ? crit_t'(clr_mask) : '0;

    e1rs_evt_reg #(.N(N_EVT)) u_evt (
        .clk(clk), .rst(rst), .set_i(hits), .clr_i(clrs), .evt_q(evts)
    );

    assign event_status  = pack_status(evts);
    assign search_status = {fas_search, cas_search, crc_search};
endmodule

// File: rtl/e1rs_chk.sv
module e1rs_chk (
    input logic       clk,
    input logic       rst,
    input logic       fas_chk_vld,
    input logic       fas_chk_err,
    input logic       cas_chk_vld,
    input logic       cas_chk_err,
    input logic       crc_chk_vld,
    input logic       clr_wr,
    input logic [2:0] clr_mask,
    input logic [7:0] event_status
);
    // R1: the FAS event rises only after an errored FAS check
    a_r1_fas_needs_err: assert property (@(posedge clk) disable iff (rst)
        (!event_status[1] && !(fas_chk_vld && fas_chk_err)) |=> !event_status[1]);

    // R2: the CAS event rises only after an errored CAS check
    a_r2_cas_needs_err: assert property (@(posedge clk) disable iff (rst)
        (!event_status[0] && !(cas_chk_vld && cas_chk_err)) |=> !event_status[0]);

    // R4: the CRC event rises only on a CRC4 strobe
    a_r4_crc_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        (!event_status[2] && !crc_chk_vld) |=> !event_status[2]);

    // R6: the upper status bits stay zero
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
        event_status[7:3] == 5'd0);

    // R7: an event bit holds unless a clear addresses it
    a_r7_sticky_fas: assert property (@(posedge clk) disable iff (rst)
        (event_status[1] && !(clr_wr && clr_mask[1])) |=> event_status[1]);

    a_r7_sticky_cas: assert property (@(posedge clk) disable iff (rst)
        (event_status[0] && !(clr_wr && clr_mask[0])) |=> event_status[0]);

    // R10: reset leaves every event clear
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (event_status == 8'd0));
endmodule

bind e1_resync_monitor e1rs_chk u_chk (.*);

// File: tb/tb_e1_resync_monitor.sv
module tb_e1_resync_monitor;
    localparam int BLK = 40;
    localparam int LIM = 37;

    logic       clk = 1'b0;
    logic       rst;
    logic       fas_chk_vld, fas_chk_err, cas_chk_vld, cas_chk_err;
    logic       crc_chk_vld, crc_chk_err;
    logic       fas_search, cas_search, crc_search;
    logic       clr_wr;
    logic [2:0] clr_mask;
    logic [7:0] event_status;
    logic [2:0] search_status;

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    int       m_fas, m_cas, m_cw, m_err;
    bit [2:0] m_ev;

    always #4 clk = ~clk;

    e1_resync_monitor #(.FAS_RUN(3), .CAS_RUN(2), .CRC_BLOCK(BLK), .CRC_LIMIT(LIM)) dut (
        .clk(clk), .rst(rst),
        .fas_chk_vld(fas_chk_vld), .fas_chk_err(fas_chk_err),
        .cas_chk_vld(cas_chk_vld), .cas_chk_err(cas_chk_err),
        .crc_chk_vld(crc_chk_vld), .crc_chk_err(crc_chk_err),
        .fas_search(fas_search), .cas_search(cas_search), .crc_search(crc_search),
        .clr_wr(clr_wr), .clr_mask(clr_mask),
        .event_status(event_status), .search_status(search_status)
    );

    function automatic bit run_hit(int r, bit v, bit e, int lim);
        return v && e && (r + 1 >= lim);
    endfunction

    function automatic int run_next(int r, bit v, bit e, int lim);
        if (!v) return r;
        if (!e) return 0;
        return (r + 1 > lim) ? lim : r + 1;
    endfunction

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic model_zero();
        m_fas = 0; m_cas = 0; m_cw = 0; m_err = 0; m_ev = 3'b000;
    endtask

    // called at a negedge; drives, clocks once, checks at the next negedge
    task automatic step(string tag, bit fv, bit fe, bit cv, bit ce, bit rv, bit re,
                        bit we, bit [2:0] msk);
        bit [2:0] hit, clr;
        bit [2:0] srch;
        fas_chk_vld = fv; fas_chk_err = fe;
        cas_chk_vld = cv; cas_chk_err = ce;
        crc_chk_vld = rv; crc_chk_err = re;
        clr_wr = we; clr_mask = msk;
        srch = 3'($urandom);
        fas_search = srch[2]; cas_search = srch[1]; crc_search = srch[0];
        #1;
        check8("R9 search_status live", {5'd0, search_status}, {5'd0, srch});
        hit[1] = run_hit(m_fas, fv, fe, 3);
        hit[0] = run_hit(m_cas, cv, ce, 2);
        hit[2] = 1'b0;
        m_fas = run_next(m_fas, fv, fe, 3);
        m_cas = run_next(m_cas, cv, ce, 2);
        if (rv) begin
            if (m_cw == BLK - 1) begin
                hit[2] = (m_err + int'(re)) >= LIM;
                m_cw = 0; m_err = 0;
            end else begin
                m_cw++; m_err += int'(re);
            end
        end
        clr  = we ? msk : 3'b000;
        m_ev = (m_ev & ~clr) | hit;
        @(posedge clk);
        @(negedge clk);
        check8(tag, event_status, {5'd0, m_ev});
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 3'b000);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        fas_chk_vld = 0; fas_chk_err = 0; cas_chk_vld = 0; cas_chk_err = 0;
        crc_chk_vld = 0; crc_chk_err = 0; clr_wr = 0; clr_mask = 0;
        fas_search = 0; cas_search = 0; crc_search = 0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_zero();
        check8("R10 reset state", event_status, 8'h00);
    endtask

    task automatic crc_block(string tag, int errs);
        for (int i = 0; i < BLK; i++)
            step(tag, 0, 0, 0, 0, 1, (i >= BLK - errs), 0, 3'b000);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1E1));
        @(negedge clk);
        do_reset();

        // R1: three consecutive FAS errors
        step("R1 fas err 1", 1, 1, 0, 0, 0, 0, 0, 3'b000);
        step("R1 fas err 2", 1, 1, 0, 0, 0, 0, 0, 3'b000);
        check8("R1 no event after two", event_status, 8'h00);
        step("R1 fas err 3", 1, 1, 0, 0, 0, 0, 0, 3'b000);
        check8("R1 event after three", event_status, 8'h02);

        // R7: clear with zero mask, then with bit 1
        step("R7 zero mask keeps", 0, 0, 0, 0, 0, 0, 1, 3'b000);
        step("R7 other bits mask keeps", 0, 0, 0, 0, 0, 0, 1, 3'b101);
        step("R7 clear fas", 0, 0, 0, 0, 0, 0, 1, 3'b010);
        check8("R7 fas cleared", event_status, 8'h00);

        // R8: run continues; set wins over clear
        step("R8 set beats clear", 1, 1, 0, 0, 0, 0, 1, 3'b010);
        check8("R8 fas still set", event_status, 8'h02);
        step("R7 clear again", 1, 0, 0, 0, 0, 0, 1, 3'b010);

        // R3: a good word breaks the run; idle strobes with err high are ignored
        step("R3 e", 1, 1, 0, 0, 0, 0, 0, 3'b000);
        step("R3 e", 1, 1, 0, 0, 0, 0, 0, 3'b000);
        step("R3 good", 1, 0, 0, 0, 0, 0, 0, 3'b000);
        step("R3 e", 1, 1, 0, 0, 0, 0, 0, 3'b000);
        step("R3 idle err", 0, 1, 0, 1, 0, 1, 0, 3'b000);
        step("R3 e", 1, 1, 0, 0, 0, 0, 0, 3'b000);
        check8("R3 no fas event", event_status, 8'h00);
        step("R3 e third", 1, 1, 0, 0, 0, 0, 0, 3'b000);
        check8("R3 fas event", event_status, 8'h02);

        // R2: CAS pair
        step("R2 cas e", 0, 0, 1, 1, 0, 0, 1, 3'b010);
        step("R2 cas good", 0, 0, 1, 0, 0, 0, 0, 3'b000);
        step("R2 cas e", 0, 0, 1, 1, 0, 0, 0, 3'b000);
        check8("R2 no cas event", event_status, 8'h00);
        step("R2 cas e second", 0, 0, 1, 1, 0, 0, 0, 3'b000);
        check8("R2 cas event", event_status, 8'h01);
        step("R7 clear cas", 0, 0, 0, 0, 0, 0, 1, 3'b001);

        // R4: exactly the limit, then one below
        crc_block("R4 block at limit", LIM);
        check8("R4 crc event at limit", event_status, 8'h04);
        step("R7 clear crc", 0, 0, 0, 0, 0, 0, 1, 3'b100);
        crc_block("R4 block below limit", LIM - 1);
        check8("R4 no crc event below", event_status, 8'h00);
        // R5: second near-miss block must not inherit errors
        crc_block("R5 no carry", LIM - 1);
        check8("R5 no crc event", event_status, 8'h00);

        // R10: reset in mid run clears the runs
        step("R10 fas e", 1, 1, 0, 0, 0, 0, 0, 3'b000);
        step("R10 fas e", 1, 1, 0, 0, 0, 0, 0, 3'b000);
        step("R10 cas e", 0, 0, 1, 1, 1, 1, 0, 3'b000);
        do_reset();
        step("R10 fas e after reset", 1, 1, 1, 1, 0, 0, 0, 3'b000);
        check8("R10 runs cleared", event_status, 8'h00);

        // random traffic, R6 checked in every compare
        for (int i = 0; i < 6000; i++) begin
            step("R6 random",
                 ($urandom % 3) != 0, ($urandom % 10) < 7,
                 ($urandom % 4) != 0, ($urandom % 10) < 6,
                 ($urandom % 2) != 0, ($urandom % 100) < 93,
                 ($urandom % 8) == 0, 3'($urandom));
        end
        idle("R7 final idle");
        finish_run();
    end
endmodule